// File: doc/BRIEF.md
# Track-Pattern Associative Memory Matcher

This block is a small associative memory for track finding. It holds a bank of stored track patterns, each made of one ternary word per detector layer. During an event, hit words arrive on eight independent layer buses. Every pattern compares each arriving word against its own stored word for that layer. A match sets a sticky per-pattern, per-layer flag that stays set for the rest of the event.

Majority logic turns each pattern's flag set into a road decision. A pattern becomes a road once the number of its flagged layers reaches a programmable threshold. A binary tree arbiter then presents the matched patterns one at a time, lowest address first. The consumer acknowledges each road, and the arbiter moves on to the next one.

Patterns are loaded through a write port before an event starts. An event-clear strobe wipes all flags and read marks between events.

Top module: `amMatcher`

## Requirements
- R1: After reset the threshold is 6, no layer flag is set, `roadValid` is low, and every stored word is value 0 with no don't-care bits.
- R2: A cycle with `wrEn` high stores `wrValue` and `wrDc` as the word for pattern `wrPat`, layer `wrLayer`.
- R3: A cycle with `hitValid[l]` high sets the layer-l flag of every pattern whose stored layer-l word matches `hitWord[l*16 +: 16]`. Once set, a flag stays set until an event clear.
- R4: A bit set to 1 in the stored don't-care word makes that bit position match either incoming value. All other bits must be equal.
- R5: Layers are compared independently. Any subset of buses may carry a word in the same cycle, and a word on bus l is never compared with another layer's stored word.
- R6: A pattern is a road when its count of set layer flags is at least the threshold.
- R7: A `thrWrEn` cycle loads `thrValue` into the threshold when the value is between 1 and 8. Any other value is ignored.
- R8: `roadValid` is high while any road is unread. `roadAddr` then gives the lowest-address unread road. `rdAck` marks that road as read at the clock edge, and `roadValid` falls once no unread road remains.
- R9: `evClear` clears every layer flag and every read mark in one cycle. Hits presented in that same cycle are discarded.
- R10: `rdAck` while `roadValid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Pattern word write strobe |
| wrPat | input | 7 | Pattern address for the write |
| wrLayer | input | 3 | Layer index for the write |
| wrValue | input | 16 | Stored value word |
| wrDc | input | 16 | Don't-care mask, 1 = bit ignored |
| thrWrEn | input | 1 | Threshold write strobe |
| thrValue | input | 4 | New threshold value |
| evClear | input | 1 | Event clear strobe |
| hitValid | input | 8 | Per-layer hit word valid |
| hitWord | input | 128 | Hit words, layer l in bits l*16 +: 16 |
| rdAck | input | 1 | Acknowledge the presented road |
| roadValid | output | 1 | An unread road is present |
| roadAddr | output | 7 | Address of the presented road |

## Verification
Some properties are checked by assertions on every cycle:
- the threshold always stays within 1 to 8;
- flags never fall except on a clear;
- a clear empties all flag and read-mark state;
- an acknowledged road is marked as read;
- a presented road really has enough flagged layers.

The directed scenarios cover what needs chosen stimulus:
- don't-care matching;
- layer isolation;
- the exact threshold boundary;
- lowest-first readout order across several roads;
- discarding of hits that coincide with a clear;
- the effect of ignored threshold values and stray acknowledges.

// File: rtl/amPkg.sv
package amPkg;
  typedef struct packed {
    logic load;
    logic clear;
    logic pop;
  } ctlStrobes_t;
endpackage

// File: rtl/amControl.sv
module amControl
  import amPkg::*;
#(
  parameter int NL = 8,
  parameter int TW = 4,
  parameter int THR_DEFAULT = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          thrWrEn,
  input  logic [TW-1:0] thrValue,
  input  logic          evClear,
  input  logic          rdAck,
  input  logic          roadValid,
  output ctlStrobes_t   strb,
  output logic [TW-1:0] thr
);
  logic [TW-1:0] thrReg;
  logic          thrOk;

  assign thrOk = (thrValue >= TW'(1)) && (thrValue <= TW'(NL));

  always_ff @(posedge clk) begin
    if (!rstN) thrReg <= TW'(THR_DEFAULT);
    else if (thrWrEn && thrOk) thrReg <= thrValue;
  end

  always_comb begin
    strb.load  = wrEn;
    strb.clear = evClear;
    strb.pop   = rdAck && roadValid && !evClear;
  end

  assign thr = thrReg;

  // R7
  thr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (thrReg >= TW'(1)) && (thrReg <= TW'(NL)));

  // R10
  no_stray_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !roadValid |-> !strb.pop);
endmodule

// File: rtl/amDatapath.sv
module amDatapath
  import amPkg::*;
#(
  parameter int N  = 128,
  parameter int NL = 8,
  parameter int W  = 16,
  parameter int TW = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strb,
  input  logic [$clog2(N)-1:0]  wrPat,
  input  logic [$clog2(NL)-1:0] wrLayer,
  input  logic [W-1:0]          wrValue,
  input  logic [W-1:0]          wrDc,
  input  logic [TW-1:0]         thr,
  input  logic [NL-1:0]         hitValid,
  input  logic [NL*W-1:0]       hitWord,
  output logic                  roadValid,
  output logic [$clog2(N)-1:0]  roadAddr
);
  localparam int AW = $clog2(N);
  localparam int LW = $clog2(NL);
  localparam int ENTRIES = N * NL;

  logic [W-1:0]         valMem [ENTRIES];
  logic [W-1:0]         dcMem  [ENTRIES];
  logic [ENTRIES-1:0]   flagVec;
  logic [ENTRIES-1:0]   setVec;
  logic [N-1:0]         done;
  logic [N-1:0]         matched;
  logic [N-1:0]         pend;
  logic [TW-1:0]        cntArr [N];
  logic                 nodeV   [2*N];
  logic [AW-1:0]        nodeIdx [2*N];
  logic [AW+LW-1:0]     wrIdx;

  assign wrIdx = {wrPat, wrLayer};

  // pattern storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valMem[i] <= '0;
        dcMem[i]  <= '0;
      end
    end else if (strb.load) begin
      valMem[wrIdx] <= wrValue;
      dcMem[wrIdx]  <= wrDc;
    end
  end

  // per-entry ternary compare and per-pattern majority count
  for (genvar p = 0; p < N; p++) begin : gPat
    for (genvar l = 0; l < NL; l++) begin : gLay
      assign setVec[p*NL+l] = hitValid[l] &&
        (((hitWord[l*W +: W] ^ valMem[p*NL+l]) & ~dcMem[p*NL+l]) == '0);
    end
    always_comb begin
      cntArr[p] = '0;
      for (int l = 0; l < NL; l++) cntArr[p] = cntArr[p] + TW'(flagVec[p*NL+l]);
    end
    assign matched[p] = (cntArr[p] >= thr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagVec <= '0;
    else if (strb.clear) flagVec <= '0;
    else flagVec <= flagVec | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= '0;
    else if (strb.clear) done <= '0;
    else if (strb.pop) done[roadAddr] <= 1'b1;
  end

  assign pend = matched & ~done;

  // readout tree: heap-indexed nodes, leaf N+i holds pattern i
  for (genvar i = 0; i < N; i++) begin : gLeaf
    assign nodeV[N+i]   = pend[i];
    assign nodeIdx[N+i] = AW'(i);
  end
  for (genvar k = 1; k < N; k++) begin : gNode
    assign nodeV[k]   = nodeV[2*k] | nodeV[2*k+1];
    assign nodeIdx[k] = nodeV[2*k] ? nodeIdx[2*k] : nodeIdx[2*k+1];
  end
  assign nodeV[0]   = 1'b0;
  assign nodeIdx[0] = '0;

  assign roadValid = nodeV[1];
  assign roadAddr  = nodeIdx[1];

  // R3
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> (($past(flagVec) & ~flagVec) == '0));

  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (flagVec == '0) && (done == '0));

  // R8
  pop_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.clear) |=> done[$past(roadAddr)]);

  // R6
  road_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    roadValid |-> (cntArr[roadAddr] >= thr) && !done[roadAddr]);
endmodule

// File: rtl/amMatcher.sv
module amMatcher
  import amPkg::*;
#(
  parameter int N  = 128,
  parameter int NL = 8,
  parameter int W  = 16,
  parameter int THR_DEFAULT = 6,
  localparam int AW = $clog2(N),
  localparam int LW = $clog2(NL),
  localparam int TW = $clog2(NL + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrPat,
  input  logic [LW-1:0] wrLayer,
  input  logic [W-1:0]  wrValue,
  input  logic [W-1:0]  wrDc,
  input  logic          thrWrEn,
  input  logic [TW-1:0] thrValue,
  input  logic          evClear,
  input  logic [NL-1:0] hitValid,
  input  logic [NL*W-1:0] hitWord,
  input  logic          rdAck,
  output logic          roadValid,
  output logic [AW-1:0] roadAddr
);
  ctlStrobes_t   strb;
  logic [TW-1:0] thr;

  amControl #(.NL(NL), .TW(TW), .THR_DEFAULT(THR_DEFAULT)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .thrWrEn(thrWrEn),
    .thrValue(thrValue), .evClear(evClear), .rdAck(rdAck),
    .roadValid(roadValid), .strb(strb), .thr(thr)
  );

  amDatapath #(.N(N), .NL(NL), .W(W), .TW(TW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPat(wrPat), .wrLayer(wrLayer),
    .wrValue(wrValue), .wrDc(wrDc), .thr(thr), .hitValid(hitValid),
    .hitWord(hitWord), .roadValid(roadValid), .roadAddr(roadAddr)
  );
endmodule

// File: tb/sim_amMatcher.sv
module sim_amMatcher;
  logic         clk = 0;
  logic         rstN = 0;
  logic         wrEn = 0;
  logic [6:0]   wrPat = 0;
  logic [2:0]   wrLayer = 0;
  logic [15:0]  wrValue = 0;
  logic [15:0]  wrDc = 0;
  logic         thrWrEn = 0;
  logic [3:0]   thrValue = 0;
  logic         evClear = 0;
  logic [7:0]   hitValid = 0;
  logic [127:0] hitWord = 0;
  logic         rdAck = 0;
  logic         roadValid;
  logic [6:0]   roadAddr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  amMatcher u0 (.*);

  task automatic chk(input string req, input logic v, input logic [6:0] a,
                     input logic ev, input logic [6:0] ea);
    checks++;
    if (v !== ev || (ev && a !== ea)) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%0d expected valid=%0b addr=%0d", req, v, a, ev, ea);
    end
  endtask

  task automatic writeWord(input int p, input int l, input logic [15:0] v, input logic [15:0] dc);
    wrEn = 1; wrPat = 7'(p); wrLayer = 3'(l); wrValue = v; wrDc = dc;
    @(negedge clk); wrEn = 0;
  endtask

  // hits on layers in mask; layer l carries base+l
  task automatic hitSame(input logic [7:0] m, input logic [15:0] base);
    hitValid = m;
    for (int l = 0; l < 8; l++) hitWord[l*16 +: 16] = base + 16'(l);
    @(negedge clk); hitValid = 0;
  endtask

  task automatic hitOne(input int l, input logic [15:0] w);
    hitValid = 8'b1 << l; hitWord = '0; hitWord[l*16 +: 16] = w;
    @(negedge clk); hitValid = 0;
  endtask

  task automatic clearEv();
    evClear = 1; @(negedge clk); evClear = 0;
  endtask

  task automatic ack();
    rdAck = 1; @(negedge clk); rdAck = 0;
  endtask

  task automatic setThr(input logic [3:0] t);
    thrWrEn = 1; thrValue = t; @(negedge clk); thrWrEn = 0;
  endtask

  task automatic tReset();
    chk("R1 reset no road", roadValid, roadAddr, 0, 0);
  endtask

  task automatic tMajority();
    for (int l = 0; l < 8; l++) writeWord(10, l, 16'h1000 + 16'(l), 16'h0);
    hitSame(8'b0001_1111, 16'h1000);
    chk("R6 five layers below default threshold 6 (R1)", roadValid, roadAddr, 0, 0);
    hitSame(8'b0010_0000, 16'h1000);
    chk("R3 R6 sixth layer makes road", roadValid, roadAddr, 1, 10);
    hitOne(6, 16'h7777);
    chk("R3 flags sticky after mismatching hit", roadValid, roadAddr, 1, 10);
  endtask

  task automatic tReadout();
    clearEv();
    for (int l = 0; l < 8; l++) begin
      writeWord(3, l, 16'h1000 + 16'(l), 16'h0);
      writeWord(50, l, 16'h1000 + 16'(l), 16'h0);
    end
    hitSame(8'hFF, 16'h1000);
    chk("R2 R8 lowest road first", roadValid, roadAddr, 1, 3);
    ack();
    chk("R8 second road", roadValid, roadAddr, 1, 10);
    ack();
    chk("R8 third road", roadValid, roadAddr, 1, 50);
    ack();
    chk("R8 valid drops when empty", roadValid, roadAddr, 0, 0);
    ack();
    hitSame(8'hFF, 16'h1000);
    chk("R10 stray ack harmless, read marks hold", roadValid, roadAddr, 0, 0);
    clearEv();
    chk("R9 clear empties roads", roadValid, roadAddr, 0, 0);
    hitSame(8'hFF, 16'h1000);
    chk("R9 read marks cleared, road 3 again", roadValid, roadAddr, 1, 3);
    clearEv();
    evClear = 1; hitValid = 8'hFF;
    for (int l = 0; l < 8; l++) hitWord[l*16 +: 16] = 16'h1000 + 16'(l);
    @(negedge clk); evClear = 0; hitValid = 0;
    chk("R9 hits during clear discarded", roadValid, roadAddr, 0, 0);
  endtask

  task automatic tDontCare();
    setThr(4'd1);
    writeWord(20, 0, 16'h2200, 16'h00FF);
    hitOne(0, 16'h22AB);
    chk("R4 R7 don't-care bits match", roadValid, roadAddr, 1, 20);
    clearEv();
    hitOne(0, 16'h23AB);
    chk("R4 cared bit mismatch no road", roadValid, roadAddr, 0, 0);
    hitOne(1, 16'h2200);
    chk("R5 word on other layer not compared", roadValid, roadAddr, 0, 0);
  endtask

  task automatic tThreshold();
    setThr(4'd0);
    setThr(4'd9);
    hitOne(0, 16'h2255);
    chk("R7 values 0 and 9 ignored, threshold stays 1", roadValid, roadAddr, 1, 20);
    clearEv();
    setThr(4'd8);
    hitSame(8'b0111_1111, 16'h1000);
    chk("R7 R5 seven of eight below threshold 8", roadValid, roadAddr, 0, 0);
    hitSame(8'b1000_0000, 16'h1000);
    chk("R7 eighth layer reaches threshold 8", roadValid, roadAddr, 1, 3);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    for (int p = 0; p < 128; p++)
      for (int l = 0; l < 8; l++)
        writeWord(p, l, {4'hA, 7'(p), 3'(l), 2'b00}, 16'h0);
    tMajority();
    tReadout();
    tDontCare();
    tThreshold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule